// File: doc/BRIEF.md
# Table-Driven Quad-SPI Flash Sequence Engine

This block runs a single serial-flash transaction whose shape comes from a table held in the block. Software fills the table with 16-bit instructions. Each instruction carries an opcode, a lane-width code and an 8-bit argument. A start command picks one of the stored sequences and gives the byte count of its data phase. The engine then walks the sequence from its first slot. While it runs it holds chip select low, toggles the serial clock and drives or samples one, two or four data lines. It sends command and mode bytes, idles through dummy clocks and moves data bytes between the flash and two byte-wide FIFOs, one for transmit and one for receive.

When the sequence ends, the engine releases chip select and sets a sticky completion flag. The flag raises an interrupt when its enable input is high. An opcode the engine does not recognise ends the sequence early and also sets an error flag. Each serial clock period is two system clock cycles long, with the clock low first and high second.

Top module: `qspi_seq_engine`

## Requirements
- R1: An instruction is 16 bits: opcode in bits 15:10, lane code in bits 9:8, argument in bits 7:0. A 32-bit table word holds two instructions, and the even-numbered slot sits in bits 15:0. Sequence s occupies table words 4s to 4s+3, so it has eight slots. Every start begins at slot 0.
- R2: Lane code 0 selects one line, 1 selects two and 2 selects four. Opcode 1 (command) and opcode 4 (mode byte) shift the argument out MSB first, `io_oe` covering exactly the used lanes. One line uses io[0]. Two lanes carry the bit pair on io[1:0]. Four lanes carry the nibble on io[3:0]. The higher bit always goes on the higher-numbered line.
- R3: Opcode 12 (dummy) produces as many serial clock periods as its argument (1 to 64), with `io_oe` at zero throughout.
- R4: Opcode 7 (read) samples the start command's byte count of bytes and pushes them into the RX FIFO in order. One line samples io[1], two lanes sample io[1:0] and four lanes sample io[3:0], first sample in the most significant position.
- R5: Opcode 8 (write) shifts out no data until the TX FIFO holds at least 16 bytes. It then sends exactly the requested byte count in FIFO order. Bytes left in the TX FIFO are discarded when the sequence ends.
- R6: The start command holds the sequence index in bits 31:24 (its low bits address the table) and the byte count in bits 7:0. A start command written while `busy` is high is ignored.
- R7: Opcode 0 (stop) ends the sequence. Chip select returns high and `busy` drops in the same cycle as the completion flag (bit 0) is set. Chip select is high whenever the engine is idle.
- R8: Writing 1 to bit 0 of `flag_wdata` clears the completion flag, and writing 1 to bit 1 clears the error flag. Writing 0 leaves a flag unchanged. `irq` is high exactly while the completion flag and `irq_en` are both 1.
- R9: Any other opcode ends the sequence as stop does and sets the error flag together with the completion flag.
- R10: A serial clock period is two clock cycles, low then high, and the serial clock is only high while chip select is low. A transaction has exactly the number of serial clock periods its instructions call for.
- R11: After reset, chip select is high, the serial clock is low, no lane is driven, and `busy`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | $clog2(NSEQ*4) | Table word index |
| tbl_wdata | input | 32 | Table word (two instructions) |
| cmd_we | input | 1 | Start command strobe |
| cmd_wdata | input | 32 | Start command: index and byte count |
| flag_we | input | 1 | Flag clear strobe |
| flag_wdata | input | 2 | Write-1-to-clear mask: bit 0 done, bit 1 error |
| irq_en | input | 1 | Interrupt enable |
| tx_push | input | 1 | Push one byte into the TX FIFO |
| tx_wdata | input | 8 | Byte to push |
| tx_level | output | $clog2(TX_DEPTH)+1 | Bytes held in the TX FIFO |
| rx_pop | input | 1 | Pop one byte from the RX FIFO |
| rx_rdata | output | 8 | Head of the RX FIFO |
| rx_level | output | $clog2(RX_DEPTH)+1 | Bytes held in the RX FIFO |
| busy | output | 1 | Sequence in progress |
| done_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky unknown-opcode flag |
| irq | output | 1 | Completion interrupt |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The bench goes after the places where the lane width and the byte count interact. It runs command, mode and data phases at one, two and four lanes. If the lane packing or the shift direction were wrong, the wrong byte would appear on the wire or land in the RX FIFO. A count that slipped by one would show up as an extra or missing serial clock period. A write that starts with fewer than 16 bytes queued must hold off. If that gate were missing, the data bytes would go out early. If padding were not discarded, it would be shifted out or left in the TX FIFO. The bench also checks that a start command arriving mid-sequence is dropped rather than restarting or chaining a second run. It checks that an unknown opcode cuts the transaction short with the error flag set, and that the write-1-to-clear flags and the interrupt gate behave bit by bit.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_MODE  = 6'd4;
  localparam logic [5:0] OP_READ  = 6'd7;
  localparam logic [5:0] OP_WRITE = 6'd8;
  localparam logic [5:0] OP_DUMMY = 6'd12;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] pad;
    logic [7:0] arg;
  } instr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_LOAD, ST_SHIFT, ST_DUMMY, ST_END
  } seq_st_t;

  // number of active lanes for a lane code
  function automatic logic [3:0] lane_cnt(input logic [1:0] pad);
    case (pad)
      2'd0:    lane_cnt = 4'd1;
      2'd1:    lane_cnt = 4'd2;
      default: lane_cnt = 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] pad);
    case (pad)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // bits presented on the lines for the current serial period
  function automatic logic [3:0] lane_out(input logic [7:0] sh, input logic [1:0] pad);
    case (pad)
      2'd0:    lane_out = {3'b000, sh[7]};
      2'd1:    lane_out = {2'b00, sh[7:6]};
      default: lane_out = sh[7:4];
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] sh, input logic [1:0] pad);
    case (pad)
      2'd0:    shift_out = {sh[6:0], 1'b0};
      2'd1:    shift_out = {sh[5:0], 2'b00};
      default: shift_out = {sh[3:0], 4'b0000};
    endcase
  endfunction

  // single-line reads sample io[1]
  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic [1:0] pad,
                                          input logic [3:0] io);
    case (pad)
      2'd0:    shift_in = {sh[6:0], io[1]};
      2'd1:    shift_in = {sh[5:0], io[1:0]};
      default: shift_in = {sh[3:0], io};
    endcase
  endfunction

  function automatic logic op_known(input logic [5:0] op);
    op_known = (op == OP_STOP) || (op == OP_CMD) || (op == OP_MODE) ||
               (op == OP_READ) || (op == OP_WRITE) || (op == OP_DUMMY);
  endfunction

endpackage

// File: rtl/qspi_byte_fifo.sv
module qspi_byte_fifo #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [7:0]               din,
  input  logic                     pop,
  output logic [7:0]               dout,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/qspi_lut_store.sv
module qspi_lut_store
  import qspi_seq_pkg::*;
#(
  parameter int NSEQ = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(NSEQ*4)-1:0]     waddr,
  input  logic [31:0]                   wdata,
  input  logic [$clog2(NSEQ)-1:0]       seq,
  input  logic [2:0]                    slot,
  output instr_t                        instr
);
  localparam int WORDS = NSEQ * 4;

  logic [31:0] tbl [WORDS];
  logic [31:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  assign word  = tbl[{seq, slot[2:1]}];
  assign instr = slot[0] ? instr_t'(word[31:16]) : instr_t'(word[15:0]);
endmodule

// File: rtl/qspi_seq_fsm.sv
module qspi_seq_fsm
  import qspi_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TLW      = 6,
  parameter int TX_START = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  input  instr_t           instr,
  output logic [2:0]       slot,
  input  logic [TLW-1:0]   tx_level,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  input  logic [3:0]       io_in,
  output logic             cs_n,
  output logic             sclk,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             busy,
  output logic             finish,
  output logic             finish_err
);
  seq_st_t          st, adv_st;
  logic [2:0]       pc;
  logic [CNT_W-1:0] left;
  logic [7:0]       sh, dcnt;
  logic [3:0]       bits, lanes;
  logic [1:0]       pad_r;
  logic             ph, rd_mode, data_r, first, err_r, load_ok, byte_end;

  assign lanes    = lane_cnt(pad_r);
  assign adv_st   = (pc == 3'd7) ? ST_END : ST_DEC;
  assign load_ok  = rd_mode ? !rx_full
                  : (first ? (tx_level >= TLW'(TX_START)) : (tx_level != '0));
  assign byte_end = (st == ST_SHIFT) && ph && (bits == lanes);

  assign slot       = pc;
  assign tx_pop     = (st == ST_LOAD) && !rd_mode && load_ok;
  assign rx_push    = byte_end && data_r && rd_mode;
  assign rx_byte    = shift_in(sh, pad_r, io_in);
  assign cs_n       = (st == ST_IDLE);
  assign sclk       = ph && ((st == ST_SHIFT) || (st == ST_DUMMY));
  assign io_oe      = ((st == ST_SHIFT) && !rd_mode) ? lane_mask(pad_r) : 4'b0000;
  assign io_out     = lane_out(sh, pad_r) & io_oe;
  assign busy       = (st != ST_IDLE);
  assign finish     = (st == ST_END);
  assign finish_err = finish && err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pc <= '0; left <= '0; sh <= '0; dcnt <= '0; bits <= '0;
      pad_r <= '0; ph <= 1'b0; rd_mode <= 1'b0; data_r <= 1'b0; first <= 1'b0;
      err_r <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          left <= start_cnt; pc <= '0; err_r <= 1'b0; st <= ST_DEC;
        end
        ST_DEC: begin
          ph <= 1'b0;
          case (instr.op)
            OP_STOP: st <= ST_END;
            OP_CMD, OP_MODE: begin
              sh <= instr.arg; pad_r <= instr.pad; rd_mode <= 1'b0;
              data_r <= 1'b0; bits <= 4'd8; st <= ST_SHIFT;
            end
            OP_DUMMY: begin
              if (instr.arg == '0) begin pc <= pc + 1'b1; st <= adv_st; end
              else begin dcnt <= instr.arg; st <= ST_DUMMY; end
            end
            OP_READ, OP_WRITE: begin
              if (left == '0) begin pc <= pc + 1'b1; st <= adv_st; end
              else begin
                pad_r <= instr.pad; rd_mode <= (instr.op == OP_READ);
                data_r <= 1'b1; first <= 1'b1; st <= ST_LOAD;
              end
            end
            default: begin err_r <= 1'b1; st <= ST_END; end
          endcase
        end
        ST_LOAD: if (load_ok) begin
          if (!rd_mode) begin sh <= tx_data; first <= 1'b0; end
          bits <= 4'd8; ph <= 1'b0; st <= ST_SHIFT;
        end
        ST_SHIFT: begin
          ph <= !ph;
          if (ph) begin
            sh   <= rd_mode ? shift_in(sh, pad_r, io_in) : shift_out(sh, pad_r);
            bits <= bits - lanes;
            if (byte_end) begin
              if (data_r && (left != CNT_W'(1))) begin
                left <= left - 1'b1; st <= ST_LOAD;
              end else begin
                if (data_r) left <= left - 1'b1;
                pc <= pc + 1'b1; st <= adv_st;
              end
            end
          end
        end
        ST_DUMMY: begin
          ph <= !ph;
          if (ph) begin
            dcnt <= dcnt - 1'b1;
            if (dcnt == 8'd1) begin pc <= pc + 1'b1; st <= adv_st; end
          end
        end
        ST_END:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_seq_engine.sv
module qspi_seq_engine
  import qspi_seq_pkg::*;
#(
  parameter int NSEQ     = 16,
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 32,
  parameter int CNT_W    = 8,
  parameter int TX_START = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tbl_we,
  input  logic [$clog2(NSEQ*4)-1:0]     tbl_addr,
  input  logic [31:0]                   tbl_wdata,
  input  logic                          cmd_we,
  input  logic [31:0]                   cmd_wdata,
  input  logic                          flag_we,
  input  logic [1:0]                    flag_wdata,
  input  logic                          irq_en,
  input  logic                          tx_push,
  input  logic [7:0]                    tx_wdata,
  output logic [$clog2(TX_DEPTH):0]     tx_level,
  input  logic                          rx_pop,
  output logic [7:0]                    rx_rdata,
  output logic [$clog2(RX_DEPTH):0]     rx_level,
  output logic                          busy,
  output logic                          done_flag,
  output logic                          err_flag,
  output logic                          irq,
  output logic                          cs_n,
  output logic                          sclk,
  output logic [3:0]                    io_out,
  output logic [3:0]                    io_oe,
  input  logic [3:0]                    io_in
);
  localparam int SW  = $clog2(NSEQ);
  localparam int TLW = $clog2(TX_DEPTH) + 1;

  instr_t     instr;
  logic [2:0] slot;
  logic       start, tx_pop, rx_push, rx_full, finish, finish_err;
  logic       tx_full_unused, tx_empty_unused, rx_empty_unused;
  logic [7:0] tx_head, rx_byte;
  logic [SW-1:0] seq_sel;
  logic [SW-1:0] seq_r;

  assign start = cmd_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seq_r <= '0;
    else if (start) seq_r <= cmd_wdata[24 +: SW];
  end
  assign seq_sel = start ? cmd_wdata[24 +: SW] : seq_r;

  qspi_lut_store #(.NSEQ(NSEQ)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .seq(seq_sel), .slot(slot), .instr(instr)
  );

  qspi_byte_fifo #(.DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(finish), .push(tx_push), .din(tx_wdata),
    .pop(tx_pop), .dout(tx_head), .level(tx_level), .full(tx_full_unused),
    .empty(tx_empty_unused)
  );

  qspi_byte_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_rdata), .level(rx_level), .full(rx_full),
    .empty(rx_empty_unused)
  );

  qspi_seq_fsm #(.CNT_W(CNT_W), .TLW(TLW), .TX_START(TX_START)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(cmd_wdata[CNT_W-1:0]),
    .instr(instr), .slot(slot), .tx_level(tx_level), .tx_data(tx_head),
    .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_byte(rx_byte),
    .io_in(io_in), .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe),
    .busy(busy), .finish(finish), .finish_err(finish_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (finish)                           done_flag <= 1'b1;
      else if (flag_we && flag_wdata[0])    done_flag <= 1'b0;
      if (finish_err)                       err_flag  <= 1'b1;
      else if (flag_we && flag_wdata[1])    err_flag  <= 1'b0;
    end
  end

  assign irq = done_flag && irq_en;
endmodule

// File: rtl/qspi_seq_engine_chk.sv
module qspi_seq_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       done_flag,
  input logic       err_flag,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       rx_full
);
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);                                                    // R7
  AST_SCLK_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);                                                    // R10
  AST_SCLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> !sclk);                                             // R10
  AST_DONE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> ($past(busy) && !busy));                       // R7
  AST_LANE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111)); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> done_flag);                                     // R9
  AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_pop);                                                 // R5
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);                                              // R4
endmodule

bind qspi_seq_engine qspi_seq_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sclk(sclk),
  .io_oe(io_oe), .done_flag(done_flag), .err_flag(err_flag),
  .tx_pop(tx_pop), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/qspi_seq_engine_tb.sv
module qspi_seq_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        flag_we = 1'b0;
  logic [1:0]  flag_wdata = '0;
  logic        irq_en = 1'b0;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_wdata = '0;
  logic [5:0]  tx_level;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_rdata;
  logic [5:0]  rx_level;
  logic        busy, done_flag, err_flag, irq, cs_n, sclk;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  int n_chk = 0;
  int n_bad = 0;

  qspi_seq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_en(irq_en),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_level(rx_level), .busy(busy),
    .done_flag(done_flag), .err_flag(err_flag), .irq(irq), .cs_n(cs_n),
    .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #2 clk = !clk;   // 250 MHz

  // flash model: records each rising serial clock, supplies read data
  logic [3:0] cap_out [256];
  logic [3:0] cap_oe  [256];
  int   ne = 0;
  int   last_edges = 0;
  logic prev_sclk = 1'b0;

  function automatic logic [3:0] flash_nib(input int e);
    flash_nib = 4'((e * 5) + 3);
  endfunction

  always @(negedge clk) begin
    if (!cs_n) begin
      if (sclk && !prev_sclk && ne < 256) begin
        cap_out[ne] = io_out;
        cap_oe[ne]  = io_oe;
        io_in <= flash_nib(ne);
        ne = ne + 1;
      end
    end else if (ne != 0) begin
      last_edges = ne;
      ne = 0;
    end
    prev_sclk = sclk;
  end

  function automatic int lanes_of(input int p);
    lanes_of = (p == 0) ? 1 : (p == 1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] exp_rd(input int s, input int l);
    logic [7:0] b = '0;
    for (int k = 0; k < 8 / l; k++) begin
      logic [3:0] n = flash_nib(s + k);
      if (l == 1)      b = {b[6:0], n[1]};
      else if (l == 2) b = {b[5:0], n[1:0]};
      else             b = {b[3:0], n};
    end
    exp_rd = b;
  endfunction

  function automatic logic [7:0] cap_byte(input int s, input int l);
    logic [7:0] b = '0;
    for (int k = 0; k < 8 / l; k++) begin
      logic [3:0] n = cap_out[s + k];
      if (l == 1)      b = {b[6:0], n[0]};
      else if (l == 2) b = {b[5:0], n[1:0]};
      else             b = {b[3:0], n};
    end
    cap_byte = b;
  endfunction

  function automatic logic [7:0] tx_pat(input int i);
    tx_pat = 8'(8'h3C + i * 29);
  endfunction

  function automatic logic [15:0] ins(input logic [5:0] op, input logic [1:0] pad,
                                      input logic [7:0] arg);
    ins = {op, pad, arg};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input int a, input logic [31:0] d);
    @(negedge clk); tbl_we = 1'b1; tbl_addr = 6'(a); tbl_wdata = d;
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic load_seq(input int seq, input logic [15:0] s [8]);
    for (int w = 0; w < 4; w++) wr_tbl(seq * 4 + w, {s[2*w+1], s[2*w]});
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_push = 1'b1; tx_wdata = b;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic go(input int seq, input int cnt);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = {4'd0, 4'(seq), 16'd0, 8'(cnt)};
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_flag && t < 20000) begin @(negedge clk); t++; end
    if (!done_flag) chk("R7 completion", 32'd0, 32'd1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic clr_flags(input logic [1:0] m);
    @(negedge clk); flag_we = 1'b1; flag_wdata = m;
    @(negedge clk); flag_we = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk); b = rx_rdata; rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  // {seq4, cmd8, cpad2, mode_en1, mode8, mpad2, dummy8, dop2(1 rd,2 wr), dpad2, cnt8}
  localparam int NV = 7;
  localparam logic [44:0] VEC [NV] = '{
    {4'd3,  8'h9F, 2'd0, 1'b0, 8'h00, 2'd0, 8'd0,  2'd1, 2'd0, 8'd3},
    {4'd5,  8'hEB, 2'd0, 1'b1, 8'hA5, 2'd2, 8'd4,  2'd1, 2'd2, 8'd8},
    {4'd15, 8'h02, 2'd0, 1'b1, 8'h5A, 2'd0, 8'd0,  2'd2, 2'd0, 8'd4},
    {4'd0,  8'h32, 2'd0, 1'b0, 8'h00, 2'd0, 8'd0,  2'd2, 2'd2, 8'd16},
    {4'd7,  8'h3B, 2'd0, 1'b1, 8'hC3, 2'd1, 8'd8,  2'd1, 2'd1, 8'd5},
    {4'd9,  8'h06, 2'd2, 1'b0, 8'h00, 2'd0, 8'd0,  2'd0, 2'd0, 8'd0},
    {4'd12, 8'h0B, 2'd0, 1'b0, 8'h00, 2'd0, 8'd64, 2'd1, 2'd0, 8'd1}
  };

  task automatic run_vec(input logic [44:0] v);
    int seq = int'(v[44:41]);
    int cl = lanes_of(int'(v[32:31]));
    int ml = lanes_of(int'(v[21:20]));
    int dl = lanes_of(int'(v[9:8]));
    int dum = int'(v[19:12]);
    int dop = int'(v[11:10]);
    int cnt = int'(v[7:0]);
    int i = 1;
    int s, e_exp;
    logic [15:0] sq [8];
    logic [7:0] b;
    for (int k = 0; k < 8; k++) sq[k] = 16'h0000;
    sq[0] = ins(6'd1, v[32:31], v[40:33]);
    if (v[30])    begin sq[i] = ins(6'd4, v[21:20], v[29:22]); i++; end
    if (dum != 0) begin sq[i] = ins(6'd12, 2'd0, 8'(dum)); i++; end
    if (dop != 0) begin sq[i] = ins((dop == 1) ? 6'd7 : 6'd8, v[9:8], 8'h00); i++; end
    load_seq(seq, sq);
    if (dop == 2) for (int k = 0; k < ((cnt < 16) ? 16 : cnt); k++) push(tx_pat(k));
    go(seq, cnt);
    wait_done();
    s = 8 / cl + (v[30] ? 8 / ml : 0) + dum;
    e_exp = s + ((dop != 0) ? cnt * 8 / dl : 0);
    chk("R10 serial period count", 32'(last_edges), 32'(e_exp));
    chk("R2 command byte", 32'(cap_byte(0, cl)), 32'(v[40:33]));
    chk("R2 command lane enable", 32'(cap_oe[0]), 32'((1 << cl) - 1));
    if (v[30]) chk("R2 mode byte", 32'(cap_byte(8 / cl, ml)), 32'(v[29:22]));
    if (dum != 0) chk("R3 dummy lanes idle", 32'(cap_oe[s - 1]), 32'd0);
    if (dop == 2) begin
      for (int k = 0; k < cnt; k++)
        chk("R5 write byte", 32'(cap_byte(s + k * 8 / dl, dl)), 32'(tx_pat(k)));
      chk("R5 padding discarded", 32'(tx_level), 32'd0);
    end
    if (dop == 1) begin
      chk("R4 rx level", 32'(rx_level), 32'(cnt));
      for (int k = 0; k < cnt; k++) begin
        pop_rx(b);
        chk("R4 read byte", 32'(b), 32'(exp_rd(s + k * 8 / dl, dl)));
      end
    end
    chk("R7 idle after stop", {30'd0, busy, cs_n}, 32'd1);
    chk("R7 done flag", 32'(done_flag), 32'd1);
    chk("R1 no error on known opcodes", 32'(err_flag), 32'd0);
    clr_flags(2'b11);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] sq [8];
    logic [7:0] b;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {26'd0, cs_n, sclk, busy, done_flag, err_flag, irq}, 32'h20);
    chk("R11 reset lanes", 32'(io_oe), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(VEC[v]);

    // R6: start while busy is ignored (sequence 12: cmd, 64 dummy, 1-byte read)
    go(12, 1);
    repeat (20) @(negedge clk);
    go(3, 3);
    wait_done();
    chk("R6 busy start ignored edges", 32'(last_edges), 32'd80);
    chk("R6 busy start ignored rx", 32'(rx_level), 32'd1);
    pop_rx(b);
    repeat (40) @(negedge clk);
    chk("R6 no second run", {31'd0, busy}, 32'd0);
    clr_flags(2'b11);

    // R5: write holds until 16 bytes queued (sequence 15: cmd, mode, 4-byte write)
    for (int k = 0; k < 15; k++) push(tx_pat(k + 50));
    go(15, 4);
    repeat (200) @(negedge clk);
    chk("R5 write waits busy", 32'(busy), 32'd1);
    chk("R5 write waits no data", 32'(ne), 32'd16);
    push(tx_pat(65));
    wait_done();
    chk("R5 write after threshold edges", 32'(last_edges), 32'd48);
    chk("R5 first data byte", 32'(cap_byte(16, 1)), 32'(tx_pat(50)));
    chk("R5 leftover dropped", 32'(tx_level), 32'd0);
    clr_flags(2'b11);

    // R9: unknown opcode ends the sequence with an error
    for (int k = 0; k < 8; k++) sq[k] = 16'h0000;
    sq[0] = ins(6'd1, 2'd0, 8'h66);
    sq[1] = ins(6'd20, 2'd0, 8'h00);
    sq[2] = ins(6'd1, 2'd0, 8'hFF);
    load_seq(1, sq);
    go(1, 0);
    wait_done();
    chk("R9 stops early", 32'(last_edges), 32'd8);
    chk("R9 error and done", {30'd0, err_flag, done_flag}, 32'd3);
    chk("R9 deselected", {30'd0, busy, cs_n}, 32'd1);

    // R8: interrupt gating and write-1-to-clear
    chk("R8 irq masked", 32'(irq), 32'd0);
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    chk("R8 irq enabled", 32'(irq), 32'd1);
    clr_flags(2'b00);
    chk("R8 zero write keeps", {30'd0, err_flag, done_flag}, 32'd3);
    clr_flags(2'b01);
    chk("R8 clear done only", {29'd0, irq, err_flag, done_flag}, 32'd2);
    clr_flags(2'b10);
    chk("R8 clear error", 32'(err_flag), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule